// File: doc/BRIEF.md
# Run-Time Selectable CRC-16 / CRC-32 Checksum Engine

This block computes a checksum over a stream of data, using either a 16-bit CCITT-style CRC or the 32-bit Ethernet CRC. Software picks the algorithm and the data source by writing one 16-bit control word. Data can come from a register write port, where each write carries one, two or four bytes, or from one of two DMA byte streams.

Selecting a source while the engine is enabled starts a run and raises `busy`. For the whole run the source field is frozen. The run ends in one of three ways:
- software writes a done bit, when the source is the register port;
- the selected DMA channel marks its last byte;
- software clears the enable bit.

The result stays readable on `checksum` until the next run starts or the engine is disabled.

Top module: `crc_unit`

## Requirements
- R1: After reset, `ctrl_rd` reads 0x0000, `busy` is 0 and `checksum` reads 0x0000FFFF.
- R2: The control word layout is as follows.
  - Bits 13:8 hold the source: 0x00 none, 0x01 register port, 0x20 DMA channel 0, 0x21 DMA channel 1.
  - Bit 4 is the enable.
  - Bits 3:2 hold the algorithm: 0 selects CRC-16, 1 selects CRC-32, 2 and 3 are reserved.
  - Bits 1:0 hold the beat size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is reserved.
  - Bit 5 is a write-only done strobe that reads 0. All other bits read 0.
- R3: `busy` rises after a control write made while idle that has bit 4 = 1 and a source of 0x01, 0x20 or 0x21. The same write loads the checksum state with the initial value of the selected algorithm. A write with source 0x00 or a reserved source code does not raise `busy`.
- R4: While `busy` is 1, the source field ignores writes. The other fields still take the written value.
- R5: CRC-16 uses polynomial 0x1021 and initial value 0xFFFF, with no reflection and no final XOR. The result reads zero-extended on `checksum`; for the bytes "123456789" it is 0x29B1.
- R6: CRC-32 uses polynomial 0x04C11DB7 and initial value 0xFFFFFFFF, with reflected input and output and a final XOR of 0xFFFFFFFF. For the bytes "123456789" the result is 0xCBF43926.
- R7: With the register port as source, each `io_we` beat is folded in within one clock, least significant byte first. The beat contains the number of bytes set by the beat-size field. The new value reads on `checksum` after that clock edge.
- R8: A reserved beat size leaves the checksum state unchanged on beats. A reserved algorithm makes `checksum` read 0 and also leaves the state unchanged; restoring the algorithm shows the previous value again.
- R9: With the register port as source, a control write with bit 5 = 1 and bit 4 = 1 while busy drops `busy`. The result is held.
- R10: With a DMA channel as source, each valid byte of that channel is folded in. Bytes from the other channel and from the register port are ignored. A valid byte with its last flag is folded in and then drops `busy`.
- R11: Writing bit 4 = 0 drops `busy` and keeps the state at the initial value of the selected algorithm. As a result, `checksum` reads 0x0000FFFF for CRC-16 and 0x00000000 for CRC-32.
- R12: While idle and enabled, `checksum` holds its value as long as the algorithm field does not change, whatever arrives on the data inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| ctrl_rd | output | 16 | Control word read-back |
| io_we | input | 1 | Register-port data beat strobe |
| io_wdata | input | 32 | Register-port data beat, byte 0 in bits 7:0 |
| dma_valid | input | 2 | Per-channel byte valid |
| dma_last | input | 2 | Per-channel last-byte flag |
| dma_data | input | 16 | Channel 0 byte in bits 7:0, channel 1 byte in bits 15:8 |
| busy | output | 1 | A run holds the source lock |
| checksum | output | 32 | Current checksum, final form |

## Verification
Some properties are checked by the assertions on every cycle:
- the source field holds across every busy cycle;
- `busy` is never high while the enable bit is low;
- a busy run always has a legal source code;
- the checksum stays still while the engine is idle and enabled;
- register-port beats with a reserved beat size never move the result.

The scenarios in the bench show the rest:
- the CRC values themselves, for every algorithm and beat-size pair, against a bitwise model;
- the known check values;
- the rejection of traffic from sources that are not selected;
- the three ways a run can end.

// File: rtl/crc_unit.sv
module crc_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] ctrl_rd,
  input  logic        io_we,
  input  logic [31:0] io_wdata,
  input  logic [1:0]  dma_valid,
  input  logic [1:0]  dma_last,
  input  logic [15:0] dma_data,
  output logic        busy,
  output logic [31:0] checksum
);
  localparam logic [5:0]  SRC_IO  = 6'h01;
  localparam logic [5:0]  SRC_CH0 = 6'h20;
  localparam logic [5:0]  SRC_CH1 = 6'h21;
  localparam logic [15:0] P16     = 16'h1021;
  localparam logic [31:0] P32R    = 32'hEDB88320;

  logic [5:0]  src_q;
  logic        en_q;
  logic [1:0]  poly_q, beat_q;
  logic        busy_q;
  logic [31:0] crc_q;

  function automatic logic [31:0] step_byte(input logic [31:0] c, input logic [7:0] b, input logic wide);
    logic [31:0] r;
    r = c;
    if (wide) begin
      r = r ^ {24'h0, b};
      for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ P32R) : (r >> 1);
    end else begin
      r[15:0] = r[15:0] ^ {b, 8'h00};
      for (int k = 0; k < 8; k++) r[15:0] = r[15] ? ({r[14:0], 1'b0} ^ P16) : {r[14:0], 1'b0};
      r[31:16] = 16'h0;
    end
    return r;
  endfunction

  function automatic logic [31:0] fold_beat(input logic [31:0] c, input logic [31:0] d,
                                            input logic [1:0] bsz, input logic [1:0] p);
    logic [31:0] r;
    int nb;
    r  = c;
    nb = (p[1] || bsz == 2'd3) ? 0 : (1 << bsz);
    for (int i = 0; i < 4; i++)
      if (i < nb) r = step_byte(r, d[8*i +: 8], p[0]);
    return r;
  endfunction

  function automatic logic [31:0] init_of(input logic [1:0] p);
    return (p == 2'd0) ? 32'h0000FFFF : (p == 2'd1) ? 32'hFFFFFFFF : 32'h0;
  endfunction

  wire [5:0] w_src    = cfg_wdata[13:8];
  wire       w_src_ok = (w_src == SRC_IO) || (w_src == SRC_CH0) || (w_src == SRC_CH1);
  wire       unused_bits = ^{cfg_wdata[15:14], cfg_wdata[7:6]};

  wire       en_n   = cfg_we ? cfg_wdata[4]   : en_q;
  wire [1:0] poly_n = cfg_we ? cfg_wdata[3:2] : poly_q;

  wire start   = cfg_we && !busy_q && cfg_wdata[4] && w_src_ok;
  wire io_fin  = cfg_we && busy_q && (src_q == SRC_IO) && cfg_wdata[5] && cfg_wdata[4];
  wire io_fire = busy_q && (src_q == SRC_IO) && io_we;
  wire sel0    = busy_q && (src_q == SRC_CH0) && dma_valid[0];
  wire sel1    = busy_q && (src_q == SRC_CH1) && dma_valid[1];
  wire [7:0] dma_byte = sel1 ? dma_data[15:8] : dma_data[7:0];
  wire dma_fin = (sel0 && dma_last[0]) || (sel1 && dma_last[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      en_q   <= 1'b0;
      poly_q <= '0;
      beat_q <= '0;
      busy_q <= 1'b0;
      crc_q  <= 32'h0000FFFF;
    end else begin
      if (cfg_we) begin
        if (!busy_q) src_q <= w_src;
        en_q   <= cfg_wdata[4];
        poly_q <= cfg_wdata[3:2];
        beat_q <= cfg_wdata[1:0];
      end
      if (!en_n)                  busy_q <= 1'b0;
      else if (start)             busy_q <= 1'b1;
      else if (io_fin || dma_fin) busy_q <= 1'b0;

      if (!en_n || start)   crc_q <= init_of(poly_n);
      else if (io_fire)     crc_q <= fold_beat(crc_q, io_wdata, beat_q, poly_q);
      else if (sel0 || sel1) crc_q <= fold_beat(crc_q, {24'h0, dma_byte}, 2'd0, poly_q);
    end
  end

  assign ctrl_rd  = {2'b00, src_q, 3'b000, en_q, poly_q, beat_q};
  assign busy     = busy_q;
  assign checksum = (poly_q == 2'd1) ? ~crc_q :
                    (poly_q == 2'd0) ? {16'h0, crc_q[15:0]} : 32'h0;
endmodule

// File: rtl/crc_unit_checks.sv
module crc_unit_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic        io_we,
  input logic [15:0] ctrl_rd,
  input logic        busy,
  input logic [31:0] checksum
);
  // R4: source field frozen across a busy cycle
  assert_src_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> ctrl_rd[13:8] == $past(ctrl_rd[13:8]));

  // R11: never busy while disabled
  assert_no_busy_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rd[4] |-> !busy);

  // R3: a run always has a legal source
  assert_busy_legal_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ctrl_rd[13:8] == 6'h01 || ctrl_rd[13:8] == 6'h20 || ctrl_rd[13:8] == 6'h21));

  // R12: idle and enabled result holds
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && ctrl_rd[4] && $past(ctrl_rd[4]) && $stable(ctrl_rd[3:2]))
      |-> $stable(checksum));

  // R8: reserved beat size leaves result unchanged
  assert_resv_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_rd[13:8] == 6'h01 && ctrl_rd[1:0] == 2'd3 && io_we && !cfg_we)
      |=> $stable(checksum));
endmodule

bind crc_unit crc_unit_checks u_checks (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .io_we(io_we),
  .ctrl_rd(ctrl_rd), .busy(busy), .checksum(checksum)
);

// File: tb/test_crc_unit.sv
module test_crc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] ctrl_rd;
  logic        io_we = 1'b0;
  logic [31:0] io_wdata = '0;
  logic [1:0]  dma_valid = '0;
  logic [1:0]  dma_last = '0;
  logic [15:0] dma_data = '0;
  logic        busy;
  logic [31:0] checksum;

  int checks = 0;
  int fails = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  crc_unit i_crc_unit (.*);

  function automatic logic [15:0] cw(input logic en, input logic done, input logic [5:0] src,
                                     input logic [1:0] p, input logic [1:0] b);
    return {2'b00, src, 2'b00, done, en, p, b};
  endfunction

  function automatic logic [15:0] m16(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int k = 7; k >= 0; k--) begin
      logic fb = r[15] ^ b[k];
      r = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0);
    end
    return r;
  endfunction

  function automatic logic [31:0] m32(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c;
    for (int k = 0; k < 8; k++) begin
      logic fb = r[31] ^ b[k];
      r = {r[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
    end
    return r;
  endfunction

  function automatic logic [31:0] out32(input logic [31:0] c);
    logic [31:0] r;
    for (int k = 0; k < 32; k++) r[k] = c[31-k];
    return r ^ 32'hFFFFFFFF;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic iow(input logic [31:0] d);
    @(negedge clk); io_we = 1'b1; io_wdata = d;
    @(negedge clk); io_we = 1'b0;
  endtask

  task automatic dmab(input int ch, input logic [7:0] d, input logic last);
    @(negedge clk);
    dma_valid[ch] = 1'b1; dma_last[ch] = last; dma_data[8*ch +: 8] = d;
    @(negedge clk);
    dma_valid = '0; dma_last = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] saved;
    logic [15:0] s16;
    logic [31:0] s32;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctrl reset", {16'h0, ctrl_rd}, 32'h0);
    chk("R1 busy reset", {31'h0, busy}, 32'h0);
    chk("R1 checksum reset", checksum, 32'h0000FFFF);

    // R5 CRC-16 check value via byte beats, R9 done
    cfg(cw(1, 0, 6'h01, 2'd0, 2'd0));
    chk("R3 busy on start", {31'h0, busy}, 32'h1);
    chk("R2 ctrl readback", {16'h0, ctrl_rd}, 32'h0110);
    for (int i = 0; i < 9; i++) iow(32'h31 + i);
    chk("R5 crc16 check", checksum, 32'h000029B1);
    cfg(cw(1, 1, 6'h00, 2'd0, 2'd0));
    chk("R9 busy dropped", {31'h0, busy}, 32'h0);
    chk("R9 result held", checksum, 32'h000029B1);
    chk("R2 done reads 0", {31'h0, ctrl_rd[5]}, 32'h0);
    iow(32'h55);
    chk("R12 idle hold", checksum, 32'h000029B1);

    // R6 CRC-32 with mixed beat sizes, R4 other fields writable
    cfg(cw(1, 0, 6'h01, 2'd1, 2'd2));
    iow(32'h34333231);
    iow(32'h38373635);
    cfg(cw(1, 0, 6'h21, 2'd1, 2'd0));
    chk("R4 src held", {26'h0, ctrl_rd[13:8]}, 32'h01);
    chk("R4 beat written", {30'h0, ctrl_rd[1:0]}, 32'h0);
    chk("R4 still busy", {31'h0, busy}, 32'h1);
    iow(32'hAAAAAA39);
    chk("R6 crc32 check", checksum, 32'hCBF43926);

    // R11 disable
    cfg(cw(0, 0, 6'h01, 2'd1, 2'd0));
    chk("R11 busy cleared", {31'h0, busy}, 32'h0);
    chk("R11 crc32 init", checksum, 32'h0);
    cfg(cw(0, 0, 6'h00, 2'd0, 2'd0));
    chk("R11 crc16 init", checksum, 32'h0000FFFF);

    // R3 no start on none/reserved source
    cfg(cw(1, 0, 6'h00, 2'd0, 2'd0));
    chk("R3 none no busy", {31'h0, busy}, 32'h0);
    cfg(cw(1, 0, 6'h05, 2'd0, 2'd0));
    chk("R3 reserved no busy", {31'h0, busy}, 32'h0);

    // R7 sweep: both algorithms, all legal beat sizes
    for (int p = 0; p < 2; p++)
      for (int b = 0; b < 3; b++)
        for (int r = 0; r < 3; r++) begin
          cfg(cw(1, 0, 6'h01, p[1:0], b[1:0]));
          s16 = 16'hFFFF; s32 = 32'hFFFFFFFF;
          for (int n = 0; n < 5; n++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            iow(seed);
            for (int j = 0; j < (1 << b); j++) begin
              s16 = m16(s16, seed[8*j +: 8]);
              s32 = m32(s32, seed[8*j +: 8]);
            end
            chk($sformatf("R7 sweep p%0d b%0d", p, b), checksum,
                (p == 1) ? out32(s32) : {16'h0, s16});
          end
          cfg(cw(1, 1, 6'h00, p[1:0], b[1:0]));
          chk("R9 sweep done", {31'h0, busy}, 32'h0);
        end

    // R8 reserved beat size and algorithm
    cfg(cw(1, 0, 6'h01, 2'd0, 2'd0));
    iow(32'h31);
    saved = checksum;
    chk("R8 first byte", saved, {16'h0, m16(16'hFFFF, 8'h31)});
    cfg(cw(1, 0, 6'h01, 2'd0, 2'd3));
    iow(32'h12345678);
    iow(32'h9ABCDEF0);
    chk("R8 reserved beat", checksum, saved);
    cfg(cw(1, 0, 6'h01, 2'd2, 2'd0));
    chk("R8 reserved poly reads 0", checksum, 32'h0);
    iow(32'h77);
    cfg(cw(1, 0, 6'h01, 2'd0, 2'd0));
    chk("R8 state unchanged", checksum, saved);
    cfg(cw(1, 1, 6'h01, 2'd0, 2'd0));

    // R10 DMA channel 0, CRC-16, with foreign traffic
    cfg(cw(1, 0, 6'h20, 2'd0, 2'd0));
    chk("R10 busy ch0", {31'h0, busy}, 32'h1);
    for (int i = 0; i < 9; i++) begin
      dmab(1, 8'hEE, 1'b1);
      iow(32'h99);
      dmab(0, 8'h31 + i, i == 8);
      if (i == 4) chk("R10 still busy", {31'h0, busy}, 32'h1);
    end
    chk("R10 ch0 crc16", checksum, 32'h000029B1);
    chk("R10 last drops busy", {31'h0, busy}, 32'h0);
    dmab(0, 8'h42, 1'b0);
    chk("R12 dma after end", checksum, 32'h000029B1);

    // R10 DMA channel 1, CRC-32
    cfg(cw(1, 0, 6'h21, 2'd1, 2'd0));
    for (int i = 0; i < 9; i++) begin
      dmab(0, 8'h00, 1'b1);
      dmab(1, 8'h31 + i, i == 8);
    end
    chk("R10 ch1 crc32", checksum, 32'hCBF43926);
    chk("R10 ch1 busy dropped", {31'h0, busy}, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule